// File: doc/BRIEF.md
# Pseudo-Associative Direct-Mapped Cache

This block is a small cache controller that first looks a read up exactly as a direct-mapped cache would. The address index selects one frame, the primary frame. If that frame does not hold the block, the controller spends one more cycle probing a partner frame. The partner frame's index equals the requested index with its top bit inverted. The primary and partner frames together make a two-frame pseudo-set. A hit in the partner frame is reported as a slow hit. It also swaps the two frames, so that the block just used moves into its primary frame and the next access to it is fast.

When neither frame holds the block, the controller fetches one word from a simple memory port. The refilled block goes into the primary frame, the block that was there moves to the partner frame, and the block that was in the partner frame is dropped. Writes are write-through and no-allocate. Each write is forwarded to memory in the cycle after acceptance. A cached copy, if any, is updated in place, and a write that misses leaves the cache unchanged. Tags and data live in flip-flop arrays. The controller takes one request at a time and drops its ready signal while a second probe or a refill is under way.

Top module: `pacache`

## Requirements
- R1: After reset every frame is empty, `req_ready` is 1 and `resp_valid` is 0, so the first read of any address is a miss.
- R2: A read whose block sits in its primary frame (index = address bits [IW-1:0]) responds one cycle after acceptance with status 2'b01 (fast hit), `resp_hit`=1, the cached word, and no memory read.
- R3: A read whose block sits in the partner frame (index with bit IW-1 inverted) responds two cycles after acceptance with status 2'b10 (slow hit), `resp_hit`=1, the cached word, and no memory read.
- R4: A slow hit exchanges the two frames of the pseudo-set. A repeat read of the same address then gives a fast hit, and the block that was displaced gives a slow hit.
- R5: A read found in neither frame issues exactly one memory read of the requested address (`mem_req`=1, `mem_we`=0, a one-cycle pulse). It responds with status 2'b11 (miss), `resp_hit`=0 and the memory word. The response comes one cycle after `mem_rvalid` is sampled.
- R6: On a miss, the refilled block enters the primary frame, the old primary block moves to the partner frame, and the old partner block is discarded, so a later read of it misses.
- R7: Stored tags include address bit IW-1. Two addresses that differ only in that bit are distinct blocks: one never hits on the other's frame.
- R8: `req_ready` is 0 from the cycle after a primary-frame miss is accepted until the slow-hit or miss response is issued.
- R9: A write responds one cycle after acceptance with status 2'b00. `resp_hit` tells whether the block was cached in either frame. In that same cycle the controller issues a memory write (`mem_we`=1) with the request's address and data. A cached copy takes the new data without moving, and a write miss allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Block was found in the cache |
| resp_status | output | 2 | 00 write, 01 fast hit, 10 slow hit, 11 miss |
| resp_rdata | output | DW | Read data |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | DW | Memory read data |

## Verification
Responses are due a fixed number of cycles after acceptance:
- a fast hit or a write: one cycle;
- a slow hit: two cycles;
- a miss: three cycles plus the bench memory's latency of three, six in all.

Every scenario drives its request on a falling edge. It then counts falling edges until `resp_valid` appears and compares that count with the value above, so a response that comes early or late fails even when its data is right. A write's memory request, and the `req_ready` level after acceptance, are sampled on the first falling edge after the accepting rising edge. That is the edge where those registered outputs first change.

// File: rtl/pacache.sv
module pacache #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic [1:0]    resp_status,
  output logic [DW-1:0] resp_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int NF = 1 << IW;
  localparam int TW = AW - IW + 1;
  localparam logic [IW-1:0] FLIP = IW'(1) << (IW - 1);
  localparam logic [1:0] ST_WR = 2'b00, ST_FAST = 2'b01, ST_SLOW = 2'b10, ST_MISS = 2'b11;

  typedef enum logic [1:0] {IDLE, PROBE2, FILL} phase_t;
  phase_t ph;

  logic [NF-1:0] vld;
  logic [TW-1:0] tags [NF];
  logic [DW-1:0] data [NF];
  logic [AW-1:0] cur_addr;

  wire [AW-1:0] look = (ph == IDLE) ? req_addr : cur_addr;
  wire [IW-1:0] ip   = look[IW-1:0];
  wire [IW-1:0] is   = ip ^ FLIP;
  wire [TW-1:0] key  = look[AW-1:IW-1];
  wire hit_p = vld[ip] && (tags[ip] == key);
  wire hit_s = vld[is] && (tags[is] == key);

  assign req_ready = (ph == IDLE);
  wire accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph          <= IDLE;
      vld         <= '0;
      cur_addr    <= '0;
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_status <= ST_WR;
      resp_rdata  <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_req    <= 1'b0;
      case (ph)
        IDLE: if (accept) begin
          cur_addr <= req_addr;
          if (req_we) begin
            mem_req     <= 1'b1;
            mem_we      <= 1'b1;
            mem_addr    <= req_addr;
            mem_wdata   <= req_wdata;
            resp_valid  <= 1'b1;
            resp_status <= ST_WR;
            resp_hit    <= hit_p || hit_s;
            if (hit_p)      data[ip] <= req_wdata;
            else if (hit_s) data[is] <= req_wdata;
          end else if (hit_p) begin
            resp_valid  <= 1'b1;
            resp_status <= ST_FAST;
            resp_hit    <= 1'b1;
            resp_rdata  <= data[ip];
          end else begin
            ph <= PROBE2;
          end
        end
        PROBE2: begin
          if (hit_s) begin
            tags[ip]    <= tags[is];
            data[ip]    <= data[is];
            vld[ip]     <= vld[is];
            tags[is]    <= tags[ip];
            data[is]    <= data[ip];
            vld[is]     <= vld[ip];
            resp_valid  <= 1'b1;
            resp_status <= ST_SLOW;
            resp_hit    <= 1'b1;
            resp_rdata  <= data[is];
            ph          <= IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_addr;
            ph       <= FILL;
          end
        end
        FILL: if (mem_rvalid) begin
          tags[is]    <= tags[ip];
          data[is]    <= data[ip];
          vld[is]     <= vld[ip];
          tags[ip]    <= key;
          data[ip]    <= mem_rdata;
          vld[ip]     <= 1'b1;
          resp_valid  <= 1'b1;
          resp_status <= ST_MISS;
          resp_hit    <= 1'b0;
          resp_rdata  <= mem_rdata;
          ph          <= IDLE;
        end
        default: ph <= IDLE;
      endcase
    end
  end

  // R2
  fast_src_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_status == ST_FAST |-> $past(req_valid && req_ready && !req_we));

  // R3
  slow_wait_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_status == ST_SLOW |-> $past(!req_ready) && resp_hit);

  // R5
  miss_fill_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_status == ST_MISS |-> $past(mem_rvalid) && !resp_hit);

  // R5
  one_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |=> !mem_req);

  // R8
  busy_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> !req_ready);

  // R9
  write_thru_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> resp_valid && resp_status == ST_WR && $past(req_valid && req_ready && req_we));
endmodule

// File: tb/pacache_test.sv
`timescale 1ns/1ps
module pacache_test;
  localparam int AW = 8, DW = 32, IW = 3, LAT = 3;
  localparam logic [1:0] WR = 2'b00, FAST = 2'b01, SLOW = 2'b10, MISS = 2'b11;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_hit, mem_req, mem_we;
  logic [1:0] resp_status;
  logic [DW-1:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int tests = 0, fails = 0, nreads = 0;
  logic [DW-1:0] mem [1<<AW];
  bit pend = 0;
  int cnt = 0;
  logic [AW-1:0] paddr;

  always #2.5 clk = ~clk;

  pacache #(.AW(AW), .DW(DW), .IW(IW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_status(resp_status), .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  function automatic logic [DW-1:0] f(input int a);
    return 32'hD000_0000 | (a * 32'h0001_0203);
  endfunction

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = f(i);

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (!rst && mem_req && mem_we) mem[mem_addr] = mem_wdata;
    if (!rst && mem_req && !mem_we) begin
      nreads++;
      pend = 1;
      cnt = LAT;
      paddr = mem_addr;
    end else if (pend) begin
      if (cnt == 1) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem[paddr];
        pend = 0;
      end else cnt--;
    end
  end

  task automatic chk(input bit ok, input string r, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [1:0] est, input logic [DW-1:0] ed, input string r);
    int lat, n0, elat;
    n0 = nreads;
    elat = (est == FAST) ? 1 : (est == SLOW) ? 2 : LAT + 3;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    // R8: busy after a primary miss, ready after a fast hit
    chk(req_ready == (est == FAST), "R8", "ready after accept", 32'(req_ready), 32'(est == FAST));
    while (!resp_valid && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == elat, r, "latency", 32'(lat), 32'(elat));
    chk(resp_status == est, r, "status", 32'(resp_status), 32'(est));
    chk(resp_hit == (est != MISS), r, "hit flag", 32'(resp_hit), 32'(est != MISS));
    chk(resp_rdata == ed, r, "data", resp_rdata, ed);
    chk(nreads - n0 == int'(est == MISS), r, "memory reads", 32'(nreads - n0), 32'(est == MISS));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ehit);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    chk(resp_valid && resp_status == WR, "R9", "write response", {29'd0, resp_valid, resp_status}, 32'h4);
    chk(resp_hit == ehit, "R9", "write hit flag", 32'(resp_hit), 32'(ehit));
    chk(mem_req && mem_we && mem_addr == a, "R9", "memory write addr", 32'(mem_addr), 32'(a));
    chk(mem_wdata == d, "R9", "memory write data", mem_wdata, d);
    chk(req_ready, "R9", "ready after write", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !resp_valid, "R1", "idle after reset", {30'd0, req_ready, resp_valid}, 32'h2);
    rd(8'h10, MISS, f(8'h10), "R1");
  endtask

  task automatic t_fast_slow;
    rd(8'h10, FAST, f(8'h10), "R2");
    rd(8'h20, MISS, f(8'h20), "R5");
    rd(8'h10, SLOW, f(8'h10), "R3");
    rd(8'h10, FAST, f(8'h10), "R4");
    rd(8'h20, SLOW, f(8'h20), "R4");
  endtask

  task automatic t_replace;
    rd(8'h30, MISS, f(8'h30), "R6");
    rd(8'h10, MISS, f(8'h10), "R6");
    rd(8'h14, MISS, f(8'h14), "R7");
    rd(8'h30, FAST, f(8'h30), "R6");
    rd(8'h14, FAST, f(8'h14), "R7");
  endtask

  task automatic t_write;
    wr(8'h30, 32'h1111_2222, 1'b1);
    rd(8'h30, FAST, 32'h1111_2222, "R9");
    wr(8'h40, 32'h3333_4444, 1'b0);
    rd(8'h40, MISS, 32'h3333_4444, "R9");
    wr(8'h30, 32'h5555_6666, 1'b1);
    rd(8'h30, SLOW, 32'h5555_6666, "R9");
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_fast_slow();
    t_replace();
    t_write();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule